// File: doc/BRIEF.md
# Handshake-Paced Two-Operand Coprocessor Slave

This block is the responder side of a fully interlocked request/acknowledge link. A master shares a single data word with it. Each operation takes two complete four-phase exchanges. In the first exchange, the slave takes operand one when it sees the acknowledge line rise, and takes operand two when it sees the line fall. The slave then spends a fixed number of clocks computing, places the result on its data output, and answers the second exchange. The master reads the result once it sees the request rise for the second time, then lowers acknowledge to close the operation.

Flow control comes entirely from the two control wires. The slave holds back the master by not yet raising or lowering its request. The master holds back the slave by keeping acknowledge at its current level for as long as it likes. Neither side moves past a level change until the other side has matched it, so the result is independent of either side's speed. The operation (sum, difference or bitwise exclusive-or) is chosen at build time. The compute delay is a build-time count from 0 to 15.

Top module: `hs_coproc_slave`

## Requirements
- R1: A synchronous reset drives `req_out` low and `data_out` to zero, clears both operand registers, and leaves the slave waiting for the first rise of `ack_in`.
- R2: `req_out` rises only one clock after `ack_in` was sampled high. Once raised, it stays high for as long as `ack_in` stays high.
- R3: `req_out` falls only one clock after `ack_in` was sampled low.
- R4: Operand one is the value of `data_in` at the clock edge where the slave first samples `ack_in` high in an operation.
- R5: Operand two is the value of `data_in` at the clock edge where the slave next samples `ack_in` low.
- R6: When `req_out` rises for the second time in an operation, `data_out` equals f(operand one, operand two). With the default operation, f is the 32-bit sum modulo 2^32; the other choices are operand one minus operand two, and bitwise exclusive-or.
- R7: The second rise of `req_out` comes no earlier than COMPUTE_CYCLES+2 clocks after the first fall. If `ack_in` is already high, it comes exactly COMPUTE_CYCLES+2 clocks after the first fall.
- R8: `data_out` is zero outside the result window. It is zero while operands are being taken and during the compute delay. It holds the result unchanged until the edge where `req_out` falls for the second time, and is zero from then on.
- R9: Each operation uses exactly two high/low pulses of `req_out`. After the second pulse the slave starts the next operation by treating the next rise of `ack_in` as operand one.
- R10: Changes on `data_in` at any edge other than the two capture edges do not affect the result.
- R11: The result does not depend on how long the master holds each level of `ack_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | W | Shared data word written by the master |
| data_out | output | W | Result word read by the master; zero outside the result window |
| ack_in | input | 1 | Acknowledge from the master (the master's request wire) |
| req_out | output | 1 | Request to the master (the master's acknowledge wire) |

## Verification
The main function is driven with operand pairs that separate the cases that matter. Carry-out wrap to zero shows the sum is taken modulo 2^32. Identical operands show that repeated values are captured because of the handshake and not because the value changed. A zero operand and large mixed-bit values catch swapped or stale operands. Each pair runs at several master paces, from immediate responses to long holds on each level, which shows the result does not depend on speed and that requests are only answered at matched levels. The data input is overwritten during the compute delay and the result window, which shows that only the two capture edges count. With zero hold, the distance between the two request pulses is measured to pin down the compute delay.

// File: rtl/hs_coproc_pkg.sv
package hs_coproc_pkg;

  typedef enum logic [1:0] {
    HS_OP_ADD = 2'd0,
    HS_OP_SUB = 2'd1,
    HS_OP_XOR = 2'd2
  } hs_op_e;

  typedef enum logic [2:0] {
    ST_TAKE_A  = 3'd0,
    ST_TAKE_B  = 3'd1,
    ST_CALC    = 3'd2,
    ST_GIVE_HI = 3'd3,
    ST_GIVE_LO = 3'd4
  } hs_state_e;

  function automatic logic [31:0] hs_ref_op(input hs_op_e op,
                                            input logic [31:0] x,
                                            input logic [31:0] y);
    case (op)
      HS_OP_SUB: return x - y;
      HS_OP_XOR: return x ^ y;
      default:   return x + y;
    endcase
  endfunction

endpackage

// File: rtl/hs_coproc_ctrl.sv
module hs_coproc_ctrl
  import hs_coproc_pkg::*;
#(
  parameter int unsigned COMPUTE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_in,
  output logic req_out,
  output logic cap_a,
  output logic cap_b,
  output logic load_res,
  output logic show_res
);

  localparam int unsigned CNT_W = $clog2(COMPUTE_CYCLES + 2);

  hs_state_e        st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             req_nx;

  always_comb begin
    st_nx    = st;
    cnt_nx   = cnt;
    req_nx   = req_out;
    cap_a    = 1'b0;
    cap_b    = 1'b0;
    load_res = 1'b0;
    case (st)
      ST_TAKE_A: if (ack_in) begin
        cap_a  = 1'b1;
        req_nx = 1'b1;
        st_nx  = ST_TAKE_B;
      end
      ST_TAKE_B: if (!ack_in) begin
        cap_b  = 1'b1;
        req_nx = 1'b0;
        cnt_nx = CNT_W'(COMPUTE_CYCLES);
        st_nx  = ST_CALC;
      end
      ST_CALC: begin
        if (cnt == '0) begin
          load_res = 1'b1;
          st_nx    = ST_GIVE_HI;
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      ST_GIVE_HI: if (ack_in) begin
        req_nx = 1'b1;
        st_nx  = ST_GIVE_LO;
      end
      ST_GIVE_LO: if (!ack_in) begin
        req_nx = 1'b0;
        st_nx  = ST_TAKE_A;
      end
      default: st_nx = ST_TAKE_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_TAKE_A;
      cnt     <= '0;
      req_out <= 1'b0;
    end else begin
      st      <= st_nx;
      cnt     <= cnt_nx;
      req_out <= req_nx;
    end
  end

  assign show_res = (st == ST_GIVE_HI) || (st == ST_GIVE_LO);

endmodule

// File: rtl/hs_coproc_datapath.sv
module hs_coproc_datapath
  import hs_coproc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter hs_op_e      OP = HS_OP_ADD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_in,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic         load_res,
  input  logic         show_res,
  output logic [W-1:0] data_out
);

  logic [W-1:0] opnd_a, opnd_b, res_q, func_out;

  generate
    if (OP == HS_OP_SUB) begin : g_sub
      assign func_out = opnd_a - opnd_b;
    end else if (OP == HS_OP_XOR) begin : g_xor
      assign func_out = opnd_a ^ opnd_b;
    end else begin : g_add
      assign func_out = opnd_a + opnd_b;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_a <= '0;
      opnd_b <= '0;
      res_q  <= '0;
    end else begin
      if (cap_a)    opnd_a <= data_in;
      if (cap_b)    opnd_b <= data_in;
      if (load_res) res_q  <= func_out;
    end
  end

  assign data_out = show_res ? res_q : '0;

endmodule

// File: rtl/hs_coproc_slave.sv
module hs_coproc_slave
  import hs_coproc_pkg::*;
#(
  parameter int unsigned W              = 32,
  parameter int unsigned COMPUTE_CYCLES = 3,
  parameter hs_op_e      OP             = HS_OP_ADD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] data_out,
  input  logic         ack_in,
  output logic         req_out
);

  logic cap_a, cap_b, load_res, show_res;

  hs_coproc_ctrl #(.COMPUTE_CYCLES(COMPUTE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ack_in   (ack_in),
    .req_out  (req_out),
    .cap_a    (cap_a),
    .cap_b    (cap_b),
    .load_res (load_res),
    .show_res (show_res)
  );

  hs_coproc_datapath #(.W(W), .OP(OP)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .data_in  (data_in),
    .cap_a    (cap_a),
    .cap_b    (cap_b),
    .load_res (load_res),
    .show_res (show_res),
    .data_out (data_out)
  );

endmodule

// File: rtl/hs_coproc_slave_chk.sv
module hs_coproc_slave_chk
  import hs_coproc_pkg::*;
#(
  parameter int unsigned W              = 32,
  parameter int unsigned COMPUTE_CYCLES = 3,
  parameter hs_op_e      OP             = HS_OP_ADD
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] data_in,
  input logic [W-1:0] data_out,
  input logic         ack_in,
  input logic         req_out
);

  logic         req_q, par;
  logic [W-1:0] din_q, shadow_a, shadow_b;
  logic [4:0]   low_cnt;
  logic         rise_now, fall_now;

  assign rise_now = req_out && !req_q;
  assign fall_now = !req_out && req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      par      <= 1'b0;
      din_q    <= '0;
      shadow_a <= '0;
      shadow_b <= '0;
      low_cnt  <= '0;
    end else begin
      req_q <= req_out;
      din_q <= data_in;
      if (rise_now) begin
        par <= !par;
        if (!par) shadow_a <= din_q;
      end
      if (fall_now && par) shadow_b <= din_q;
      if (req_out)                low_cnt <= '0;
      else if (low_cnt != 5'd31)  low_cnt <= low_cnt + 5'd1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!req_out && data_out == '0));

  p_raise_after_ack_r2: assert property (@(posedge clk) disable iff (rst)
    rise_now |-> $past(ack_in));

  p_lower_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
    fall_now |-> !$past(ack_in));

  p_result_value_r6: assert property (@(posedge clk) disable iff (rst)
    (rise_now && par) |-> data_out == W'(hs_ref_op(OP, 32'(shadow_a), 32'(shadow_b))));

  p_compute_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (rise_now && par) |-> low_cnt >= 5'(COMPUTE_CYCLES + 2));

  p_clear_after_op_r8: assert property (@(posedge clk) disable iff (rst)
    (fall_now && !par) |-> data_out == '0);

endmodule

bind hs_coproc_slave hs_coproc_slave_chk #(
  .W(W), .COMPUTE_CYCLES(COMPUTE_CYCLES), .OP(OP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .data_in  (data_in),
  .data_out (data_out),
  .ack_in   (ack_in),
  .req_out  (req_out)
);

// File: tb/hs_coproc_slave_bench.sv
module hs_coproc_slave_bench;
  import hs_coproc_pkg::*;

  localparam int unsigned LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] data_in = '0;
  logic [31:0] data_out;
  logic        ack_in = 1'b0;
  logic        req_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hs_coproc_slave #(.W(32), .COMPUTE_CYCLES(LAT), .OP(HS_OP_ADD)) u_hs_coproc_slave (
    .clk(clk), .rst(rst), .data_in(data_in), .data_out(data_out),
    .ack_in(ack_in), .req_out(req_out)
  );

  // {operand one, operand two, master hold cycles}
  localparam logic [71:0] VEC [0:5] = '{
    {32'h0000_0005, 32'h0000_0007, 8'd0},
    {32'hFFFF_FFFF, 32'h0000_0001, 8'd2},
    {32'h1234_5678, 32'h1234_5678, 8'd0},
    {32'h0000_0000, 32'h8000_0000, 8'd5},
    {32'hA5A5_A5A5, 32'h5A5A_5A5B, 8'd1},
    {32'h1234_5678, 32'h1234_5678, 8'd7}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_req(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (req_out !== lvl && n < 2000);
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input int hold, input bit scribble);
    int n;
    int gap;
    logic [31:0] res;
    data_in = a;
    repeat (hold) @(negedge clk);
    ack_in = 1'b1;
    wait_req(1'b1, n);
    chk(req_out === 1'b1 && n == 1, "R2 raise one clock after ack", 32'(n), 32'd1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (scribble) data_in = ~a;
      chk(req_out === 1'b1, "R2 req held while ack high", {31'd0, req_out}, 32'd1);
    end
    data_in = b;
    ack_in  = 1'b0;
    wait_req(1'b0, n);
    chk(n == 1, "R3 lower one clock after ack", 32'(n), 32'd1);
    chk(data_out === 32'd0, "R8 zero during compute", data_out, 32'd0);
    if (scribble) data_in = 32'hDEAD_BEEF;
    repeat (hold) @(negedge clk);
    ack_in = 1'b1;
    wait_req(1'b1, gap);
    res = a + b;
    chk(data_out === res, "R6 R4 R5 R11 result", data_out, res);
    if (hold == 0)
      chk(gap == LAT + 2, "R7 compute gap", 32'(gap), 32'(LAT + 2));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (scribble) data_in = 32'h0BAD_F00D ^ 32'(i);
      chk(data_out === res, "R8 R10 result held", data_out, res);
    end
    ack_in = 1'b0;
    wait_req(1'b0, n);
    chk(data_out === 32'd0, "R8 R9 zero after final low sync", data_out, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_out === 1'b0, "R1 req low in reset", {31'd0, req_out}, 32'd0);
    chk(data_out === 32'd0, "R1 data zero in reset", data_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 6; v++)
      run_op(VEC[v][71:40], VEC[v][39:8], int'(VEC[v][7:0]), v[0]);

    // R10: heavy scribbling on data_in with zero and long holds
    run_op(32'h0000_00FF, 32'h0000_0001, 0, 1'b1);
    run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 4, 1'b1);

    // R1: reset in the middle of an operation
    data_in = 32'h1111_1111;
    ack_in  = 1'b1;
    @(negedge clk);
    chk(req_out === 1'b1, "R1 setup req high", {31'd0, req_out}, 32'd1);
    rst    = 1'b1;
    ack_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk(req_out === 1'b0, "R1 req low after mid-op reset", {31'd0, req_out}, 32'd0);
    chk(data_out === 32'd0, "R1 data zero after mid-op reset", data_out, 32'd0);
    repeat (3) @(negedge clk);
    chk(req_out === 1'b0, "R1 R9 idle until ack rises", {31'd0, req_out}, 32'd0);
    run_op(32'h0000_0010, 32'h0000_0020, 0, 1'b0);
    run_op(32'hFFFF_FFFE, 32'h0000_0003, 3, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule